// File: doc/BRIEF.md
# LSTM Cell Element Pipeline

This block produces the hidden state h_t and the cell state c_t of one LSTM layer, one element per hidden index. It has `GROUPS` replicated lanes of four multiply-accumulate units, one unit each for the input, forget, candidate and output gates. A timestep runs in passes. In each pass, every group works on one hidden row (row = pass·GROUPS + group).

Each unit walks the row of its input weight matrix column by column against the input vector x_t. It folds in the gate bias on the first column. After the last column it adds a recurrent term that a companion block precomputes. The gate sums are turned into activations by table lookup. The cell and hidden values then follow on the two cycles after that, so each pass takes M+3 cycles.

The block reads its operands through a zero-latency read port. It drives the current column and pass numbers, and the surrounding memories return the weights, the x element, the biases and the recurrent terms in the same cycle. Each row's previous cell value is kept inside the block and carries over from one timestep to the next.

Top module: `lstm_elem_pipe`

## Requirements
- R1: After reset, `busy`, `h_valid` and `done` are 0, and every stored previous-cell value is 0. The first timestep after a reset therefore uses c_{t-1}=0 for all rows.
- R2: A `start` pulse sampled while the block is idle begins a timestep. A `start` sampled while `busy` is 1 has no effect: the completion time, the number of outputs and their values are unchanged.
- R3: During the M accumulation cycles of a pass, `col_idx` steps 0..M-1. On column 0 each gate accumulator loads w·x + (bias<<FB). On the later columns it adds w·x. Operands are packed with gate q (0=input, 1=forget, 2=candidate, 3=output) of group g at bits [(g·4+q)·DW +: DW] of `w_data`, `bias_data` and `rec_data`. All values are signed Q(FB).
- R4: On cycle M+1 each accumulator adds (rec<<FB). The table address is this sum arithmetically shifted right by 2·FB−AF and saturated to a signed AW-bit value a.
- R5: Activation tables: sigmoid(a) = clamp(a·2^(FB−AF−2) + 2^(FB−1), 0, 2^FB) for the input, forget and output gates. The candidate uses tanh(a) = clamp(a·2^(FB−AF), −2^FB, 2^FB).
- R6: On cycle M+2, c = sat_DW((f·c_{t-1} + i·cc) >>> FB). The value is written back for that row and used as c_{t-1} in the next timestep.
- R7: On cycle M+3, h = sat_DW((o·H(c)) >>> FB). H uses the tanh table addressed by c >>> (FB−AF), saturated to AW bits.
- R8: Counting clock edges from the edge that samples `start`, the outputs of pass p appear after edge (p+1)·(M+3). They show as a one-cycle `h_valid` with `h_row_base` = p·GROUPS, and the value for group g is at bits [g·DW +: DW] of `h_data` and `c_data`.
- R9: `done` pulses together with the last `h_valid`, after (M+3)·Y/GROUPS edges, and `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a timestep (accepted when idle) |
| x_data | input | DW | x_t element for `col_idx` |
| w_data | input | GROUPS·4·DW | Weights of the current rows at column `col_idx` |
| bias_data | input | GROUPS·4·DW | Gate biases of the current rows |
| rec_data | input | GROUPS·4·DW | Precomputed recurrent terms of the current rows |
| busy | output | 1 | Timestep in progress |
| col_idx | output | clog2(M) | Column being read |
| pass_idx | output | clog2(Y) | Current pass (rows pass·GROUPS + g) |
| h_valid | output | 1 | Results of one pass are valid |
| h_row_base | output | clog2(Y) | First row of the valid results |
| h_data | output | GROUPS·DW | Hidden outputs per group |
| c_data | output | GROUPS·DW | Cell outputs per group |
| done | output | 1 | All Y elements of h_t are complete |

## Verification
Two events can land in the same cycle. The first is the final pass's result strobe, which coincides with the end-of-timestep pulse and the return to idle. The second is a `start` request that arrives while a pass is running. The bench provokes the first on every timestep and checks that `done`, the last `h_valid`, the expected row base and a low `busy` all appear on exactly the computed edge. It provokes the second by pulsing `start` mid-pass and requiring the completion time, the output count and every h and c value to match a run without that pulse.

// File: rtl/lstm_pkg.sv
package lstm_pkg;

    localparam int N_GATES = 4;
    localparam int GATE_I  = 0;
    localparam int GATE_F  = 1;
    localparam int GATE_C  = 2;
    localparam int GATE_O  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAC,
        ST_REC,
        ST_CELL,
        ST_HOUT
    } seq_state_e;

    typedef enum logic {
        ACT_SIGMOID,
        ACT_TANH
    } act_kind_e;

    typedef struct packed {
        logic load;
        logic accum;
    } mac_ctl_t;

    function automatic longint sat_signed(input longint v, input int bits);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (bits - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Table entry for signed address a (fraction bits AF), result in Q(fb)
    function automatic longint act_value(input act_kind_e kind, input longint a,
                                         input int fb, input int af);
        longint one;
        longint v;
        one = longint'(1) <<< fb;
        if (kind == ACT_SIGMOID) begin
            v = (a <<< (fb - af - 2)) + (one >>> 1);
            if (v < 0) v = 0;
            if (v > one) v = one;
        end else begin
            v = a <<< (fb - af);
            if (v < -one) v = -one;
            if (v > one) v = one;
        end
        return v;
    endfunction

endpackage

// File: rtl/lstm_act_rom.sv
module lstm_act_rom
    import lstm_pkg::*;
#(
    parameter int        AW   = 8,
    parameter int        DW   = 16,
    parameter int        FB   = 8,
    parameter int        AF   = 4,
    parameter act_kind_e KIND = ACT_SIGMOID
) (
    input  logic [AW-1:0]        addr,
    output logic signed [DW-1:0] data
);
    localparam int DEPTH = 2 ** AW;

    logic signed [DW-1:0] tbl [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        localparam longint AV = (e < DEPTH / 2) ? longint'(e) : longint'(e) - longint'(DEPTH);
        assign tbl[e] = DW'(act_value(KIND, AV, FB, AF));
    end

    assign data = tbl[addr];
endmodule

// File: rtl/lstm_gate_mac.sv
module lstm_gate_mac
    import lstm_pkg::*;
#(
    parameter int DW    = 16,
    parameter int FB    = 8,
    parameter int ACC_W = 36
) (
    input  logic                    clk,
    input  logic                    rst,
    input  mac_ctl_t                ctl,
    input  logic signed [DW-1:0]    w,
    input  logic signed [DW-1:0]    x,
    input  logic signed [DW-1:0]    bias,
    input  logic signed [DW-1:0]    rec,
    output logic signed [ACC_W-1:0] pre
);
    logic signed [2*DW-1:0]  prod;
    logic signed [ACC_W-1:0] prod_e;
    logic signed [ACC_W-1:0] bias_e;
    logic signed [ACC_W-1:0] rec_e;
    logic signed [ACC_W-1:0] acc_q;

    assign prod   = (2*DW)'(w) * (2*DW)'(x);
    assign prod_e = ACC_W'(prod);
    assign bias_e = ACC_W'(bias) <<< FB;
    assign rec_e  = ACC_W'(rec) <<< FB;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (ctl.load) begin
            acc_q <= prod_e + bias_e;
        end else if (ctl.accum) begin
            acc_q <= acc_q + prod_e;
        end
    end

    // recurrent term folded in on the step after the last column
    assign pre = acc_q + rec_e;
endmodule

// File: rtl/lstm_cell_unit.sv
module lstm_cell_unit
    import lstm_pkg::*;
#(
    parameter int DW = 16,
    parameter int FB = 8,
    parameter int AW = 8,
    parameter int AF = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cell_en,
    input  logic                 hout_en,
    input  logic signed [DW-1:0] i_act,
    input  logic signed [DW-1:0] f_act,
    input  logic signed [DW-1:0] cc_act,
    input  logic signed [DW-1:0] o_act,
    input  logic signed [DW-1:0] c_prev,
    output logic signed [DW-1:0] c_new,
    output logic signed [DW-1:0] c_q,
    output logic signed [DW-1:0] h_q
);
    logic signed [2*DW-1:0] prod_f;
    logic signed [2*DW-1:0] prod_i;
    logic signed [2*DW:0]   c_sum;
    logic [AW-1:0]          h_addr;
    logic signed [DW-1:0]   h_tanh;
    logic signed [2*DW-1:0] prod_h;
    logic signed [DW-1:0]   h_next;

    assign prod_f = (2*DW)'(f_act) * (2*DW)'(c_prev);
    assign prod_i = (2*DW)'(i_act) * (2*DW)'(cc_act);
    assign c_sum  = (2*DW+1)'(prod_f) + (2*DW+1)'(prod_i);
    assign c_new  = DW'(sat_signed(longint'(c_sum) >>> FB, DW));

    assign h_addr = AW'(sat_signed(longint'(c_q) >>> (FB - AF), AW));

    lstm_act_rom #(
        .AW(AW), .DW(DW), .FB(FB), .AF(AF), .KIND(ACT_TANH)
    ) u_h_rom (
        .addr(h_addr),
        .data(h_tanh)
    );

    assign prod_h = (2*DW)'(o_act) * (2*DW)'(h_tanh);
    assign h_next = DW'(sat_signed(longint'(prod_h) >>> FB, DW));

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
            h_q <= '0;
        end else begin
            if (cell_en) c_q <= c_new;
            if (hout_en) h_q <= h_next;
        end
    end
endmodule

// File: rtl/lstm_seq.sv
module lstm_seq
    import lstm_pkg::*;
#(
    parameter int M      = 6,
    parameter int PASSES = 4,
    parameter int CW     = 3,
    parameter int PW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic [CW-1:0] col_idx,
    output logic [PW-1:0] pass_idx,
    output mac_ctl_t      ctl,
    output logic          act_en,
    output logic          cell_en,
    output logic          hout_en,
    output logic [PW-1:0] h_pass,
    output logic          h_valid,
    output logic          done
);
    seq_state_e    state_q;
    logic [CW-1:0] col_q;
    logic [PW-1:0] pass_q;
    logic          last_col;
    logic          last_pass;

    assign last_col  = (col_q == CW'(M - 1));
    assign last_pass = (pass_q == PW'(PASSES - 1));

    always_comb begin
        ctl.load  = (state_q == ST_MAC) && (col_q == '0);
        ctl.accum = (state_q == ST_MAC) && (col_q != '0);
        act_en    = (state_q == ST_REC);
        cell_en   = (state_q == ST_CELL);
        hout_en   = (state_q == ST_HOUT);
        busy      = (state_q != ST_IDLE);
    end

    assign col_idx  = col_q;
    assign pass_idx = pass_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            pass_q  <= '0;
            h_pass  <= '0;
            h_valid <= 1'b0;
            done    <= 1'b0;
        end else begin
            h_valid <= hout_en;
            done    <= hout_en && last_pass;
            if (hout_en) h_pass <= pass_q;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_MAC;
                        col_q   <= '0;
                        pass_q  <= '0;
                    end
                end
                ST_MAC: begin
                    if (last_col) begin
                        state_q <= ST_REC;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                ST_REC:  state_q <= ST_CELL;
                ST_CELL: state_q <= ST_HOUT;
                ST_HOUT: begin
                    col_q <= '0;
                    if (last_pass) begin
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_MAC;
                        pass_q  <= pass_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lstm_elem_pipe.sv
module lstm_elem_pipe
    import lstm_pkg::*;
#(
    parameter int M      = 6,
    parameter int Y      = 8,
    parameter int GROUPS = 2,
    parameter int DW     = 16,
    parameter int FB     = 8,
    parameter int AW     = 8,
    parameter int AF     = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [DW-1:0]              x_data,
    input  logic [GROUPS*4*DW-1:0]     w_data,
    input  logic [GROUPS*4*DW-1:0]     bias_data,
    input  logic [GROUPS*4*DW-1:0]     rec_data,
    output logic                       busy,
    output logic [$clog2(M)-1:0]       col_idx,
    output logic [$clog2(Y)-1:0]       pass_idx,
    output logic                       h_valid,
    output logic [$clog2(Y)-1:0]       h_row_base,
    output logic [GROUPS*DW-1:0]       h_data,
    output logic [GROUPS*DW-1:0]       c_data,
    output logic                       done
);
    localparam int CW     = $clog2(M);
    localparam int RW     = $clog2(Y);
    localparam int PASSES = Y / GROUPS;
    localparam int ACC_W  = 2 * DW + $clog2(M + 2) + 1;
    localparam int SHIFT  = 2 * FB - AF;

    mac_ctl_t      ctl;
    logic          act_en;
    logic          cell_en;
    logic          hout_en;
    logic [RW-1:0] h_pass;

    lstm_seq #(
        .M(M), .PASSES(PASSES), .CW(CW), .PW(RW)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .busy(busy), .col_idx(col_idx), .pass_idx(pass_idx),
        .ctl(ctl), .act_en(act_en), .cell_en(cell_en), .hout_en(hout_en),
        .h_pass(h_pass), .h_valid(h_valid), .done(done)
    );

    assign h_row_base = RW'(h_pass * RW'(GROUPS));

    logic signed [DW-1:0] c_file [Y];
    logic signed [DW-1:0] c_new  [GROUPS];
    logic [RW-1:0]        row_of [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic signed [DW-1:0] act_q [N_GATES];

        assign row_of[g] = RW'(pass_idx * RW'(GROUPS)) + RW'(g);

        for (genvar q = 0; q < N_GATES; q++) begin : g_gate
            localparam int        SL   = (g * N_GATES + q) * DW;
            localparam act_kind_e KIND = (q == GATE_C) ? ACT_TANH : ACT_SIGMOID;

            logic signed [ACC_W-1:0] pre;
            logic [AW-1:0]           addr;
            logic signed [DW-1:0]    act;

            lstm_gate_mac #(
                .DW(DW), .FB(FB), .ACC_W(ACC_W)
            ) u_mac (
                .clk(clk), .rst(rst), .ctl(ctl),
                .w(w_data[SL +: DW]), .x(x_data),
                .bias(bias_data[SL +: DW]), .rec(rec_data[SL +: DW]),
                .pre(pre)
            );

            assign addr = AW'(sat_signed(longint'(pre) >>> SHIFT, AW));

            lstm_act_rom #(
                .AW(AW), .DW(DW), .FB(FB), .AF(AF), .KIND(KIND)
            ) u_rom (
                .addr(addr),
                .data(act)
            );

            always_ff @(posedge clk) begin
                if (rst)         act_q[q] <= '0;
                else if (act_en) act_q[q] <= act;
            end
        end

        logic signed [DW-1:0] c_q;
        logic signed [DW-1:0] h_q;

        lstm_cell_unit #(
            .DW(DW), .FB(FB), .AW(AW), .AF(AF)
        ) u_cell (
            .clk(clk), .rst(rst), .cell_en(cell_en), .hout_en(hout_en),
            .i_act(act_q[GATE_I]), .f_act(act_q[GATE_F]),
            .cc_act(act_q[GATE_C]), .o_act(act_q[GATE_O]),
            .c_prev(c_file[row_of[g]]),
            .c_new(c_new[g]), .c_q(c_q), .h_q(h_q)
        );

        assign h_data[g*DW +: DW] = h_q;
        assign c_data[g*DW +: DW] = c_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < Y; r++) c_file[r] <= '0;
        end else if (cell_en) begin
            for (int g = 0; g < GROUPS; g++) c_file[row_of[g]] <= c_new[g];
        end
    end
endmodule

// File: rtl/lstm_elem_pipe_chk.sv
module lstm_elem_pipe_chk #(
    parameter int M      = 6,
    parameter int GROUPS = 2,
    parameter int DW     = 16,
    parameter int FB     = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic [$clog2(M)-1:0] col_idx,
    input logic                 h_valid,
    input logic                 done,
    input logic [GROUPS*DW-1:0] h_data
);
    // R2: an idle block takes a start
    p_idle_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3: the column never leaves 0..M-1
    p_col_range_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (col_idx <= ($clog2(M))'(M - 1)));

    // R8: results strobe for one cycle per pass
    p_hvalid_single_r8: assert property (@(posedge clk) disable iff (rst)
        h_valid |=> !h_valid);

    // R9: completion comes with the last results and an idle block
    p_done_last_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (h_valid && !busy));

    // R7: |h| never exceeds one, since |o| <= 1 and |H| <= 1
    for (genvar g = 0; g < GROUPS; g++) begin : g_hb
        p_h_bound_r7: assert property (@(posedge clk) disable iff (rst)
            h_valid |-> (($signed(h_data[g*DW +: DW]) <= $signed(DW'(1 << FB))) &&
                         ($signed(h_data[g*DW +: DW]) >= -$signed(DW'(1 << FB)))));
    end
endmodule

bind lstm_elem_pipe lstm_elem_pipe_chk #(
    .M(M), .GROUPS(GROUPS), .DW(DW), .FB(FB)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .col_idx(col_idx),
    .h_valid(h_valid), .done(done), .h_data(h_data)
);

// File: tb/tb_lstm_elem_pipe.sv
module tb_lstm_elem_pipe;
    localparam int  M      = 6;
    localparam int  Y      = 8;
    localparam int  GROUPS = 2;
    localparam int  DW     = 16;
    localparam int  FB     = 8;
    localparam int  AW     = 8;
    localparam int  AF     = 4;
    localparam int  PASSES = Y / GROUPS;
    localparam int  LAT    = (M + 3) * PASSES;
    localparam time TCLK   = 10ns;
    localparam int  WDOG   = 100000;

    logic                   clk = 0;
    logic                   rst;
    logic                   start;
    logic [DW-1:0]          x_data;
    logic [GROUPS*4*DW-1:0] w_data;
    logic [GROUPS*4*DW-1:0] bias_data;
    logic [GROUPS*4*DW-1:0] rec_data;
    logic                   busy;
    logic [$clog2(M)-1:0]   col_idx;
    logic [$clog2(Y)-1:0]   pass_idx;
    logic                   h_valid;
    logic [$clog2(Y)-1:0]   h_row_base;
    logic [GROUPS*DW-1:0]   h_data;
    logic [GROUPS*DW-1:0]   c_data;
    logic                   done;

    lstm_elem_pipe #(
        .M(M), .Y(Y), .GROUPS(GROUPS), .DW(DW), .FB(FB), .AW(AW), .AF(AF)
    ) dut (.*);

    always #(TCLK / 2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int sc_seed = 0;
    int sc_wsc = 1;
    int sc_xsc = 1;
    longint cmod [Y];

    // operand memories of the surrounding system
    function automatic longint wgen(int row, int q, int k);
        return longint'(((row * 37 + q * 11 + k * 7 + sc_seed * 13) % 29) - 14) * sc_wsc;
    endfunction
    function automatic longint xgen(int k);
        return longint'(((k * 5 + sc_seed * 3) % 17) - 8) * sc_xsc;
    endfunction
    function automatic longint bgen(int row, int q);
        return longint'(((row * 3 + q * 5 + sc_seed) % 9) - 4) * 16;
    endfunction
    function automatic longint rgen(int row, int q);
        return longint'(((row * 5 + q * 3 + sc_seed * 7) % 11) - 5) * 20;
    endfunction

    always_comb begin
        x_data = DW'(xgen(int'(col_idx)));
        for (int g = 0; g < GROUPS; g++) begin
            for (int q = 0; q < 4; q++) begin
                w_data[(g*4+q)*DW +: DW]    = DW'(wgen(int'(pass_idx) * GROUPS + g, q, int'(col_idx)));
                bias_data[(g*4+q)*DW +: DW] = DW'(bgen(int'(pass_idx) * GROUPS + g, q));
                rec_data[(g*4+q)*DW +: DW]  = DW'(rgen(int'(pass_idx) * GROUPS + g, q));
            end
        end
    end

    function automatic longint sat(longint v, int bits);
        longint hi = (longint'(1) <<< (bits - 1)) - 1;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction
    function automatic longint clampv(longint v, longint lo, longint hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction
    // R5 tables as stated
    function automatic longint sig_m(longint a);
        return clampv(a * (1 << (FB - AF - 2)) + (1 << (FB - 1)), 0, 1 << FB);
    endfunction
    function automatic longint tanh_m(longint a);
        return clampv(a * (1 << (FB - AF)), -(1 << FB), 1 << FB);
    endfunction

    // R3..R7 reference for one row; updates the stored cell value
    task automatic model_row(input int row, output longint h, output longint c);
        longint act [4];
        for (int q = 0; q < 4; q++) begin
            longint acc = bgen(row, q) <<< FB;
            longint a;
            for (int k = 0; k < M; k++) acc += wgen(row, q, k) * xgen(k);
            acc += rgen(row, q) <<< FB;
            a = sat(acc >>> (2 * FB - AF), AW);
            act[q] = (q == 2) ? tanh_m(a) : sig_m(a);
        end
        c = sat((act[1] * cmod[row] + act[0] * act[2]) >>> FB, DW);
        h = sat((act[3] * tanh_m(sat(c >>> (FB - AF), AW))) >>> FB, DW);
        cmod[row] = c;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1; start = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int r = 0; r < Y; r++) cmod[r] = 0;
    endtask

    // one timestep; poke=1 pulses start mid-pass (R2)
    task automatic run_step(input int seed, input int wsc, input int xsc, input bit poke);
        int n = 0;
        int hv = 0;
        int done_at = -1;
        int done_cnt = 0;
        sc_seed = seed; sc_wsc = wsc; sc_xsc = xsc;
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        while (n <= LAT + 4) begin
            if (poke && n == 3) start = 1;
            if (poke && n == 4) start = 0;
            if (n == 0) chk(col_idx == 0 && pass_idx == 0 && busy, "R3", "first column index", longint'(col_idx), 0);
            if (n == M - 1) chk(int'(col_idx) == M - 1, "R3", "last column index", longint'(col_idx), M - 1);
            if (h_valid) begin
                longint h;
                longint c;
                chk(n == (hv + 1) * (M + 3), "R8", "h_valid edge", n, (hv + 1) * (M + 3));
                chk(int'(h_row_base) == hv * GROUPS, "R8", "row base", longint'(h_row_base), hv * GROUPS);
                for (int g = 0; g < GROUPS; g++) begin
                    model_row(hv * GROUPS + g, h, c);
                    chk(longint'($signed(c_data[g*DW +: DW])) == c, "R6", "c value",
                        longint'($signed(c_data[g*DW +: DW])), c);
                    chk(longint'($signed(h_data[g*DW +: DW])) == h, "R7", "h value",
                        longint'($signed(h_data[g*DW +: DW])), h);
                end
                hv++;
            end
            if (done) begin
                done_cnt++;
                done_at = n;
                chk(h_valid && !busy, "R9", "done with last h and idle", longint'(busy), 0);
            end
            @(negedge clk);
            n++;
        end
        chk(hv == PASSES, poke ? "R2" : "R8", "h_valid count", hv, PASSES);
        chk(done_at == LAT, "R9", "done edge", done_at, LAT);
        chk(done_cnt == 1, poke ? "R2" : "R9", "done count", done_cnt, 1);
        chk(!busy, "R9", "idle after step", longint'(busy), 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(!busy && !h_valid && !done, "R1", "outputs after reset",
            longint'({busy, h_valid, done}), 0);
    endtask

    task automatic t_basic();        // R3 R4 R5 R6 R7 R8 R9, zero c after reset (R1)
        run_step(1, 1, 20, 0);
    endtask

    task automatic t_carry();        // R6: c_{t-1} persists across timesteps
        run_step(2, 3, 40, 0);
        run_step(3, 2, 30, 0);
    endtask

    task automatic t_saturate();     // R4: table address saturates both ways
        run_step(4, 300, 60, 0);
        run_step(5, 300, -60, 0);
    endtask

    task automatic t_busy_start();   // R2: start while busy is ignored
        run_step(6, 2, 25, 1);
    endtask

    task automatic t_reset_clears(); // R1: reset zeroes stored cell values
        do_reset();
        chk(!busy, "R1", "busy after second reset", longint'(busy), 0);
        run_step(2, 3, 40, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_carry();
        t_saturate();
        t_busy_start();
        t_reset_clears();
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule